// File: doc/BRIEF.md
# Pipelined Triple-DES Engine (Encrypt-Decrypt-Encrypt)

This block is a Triple-DES block cipher built from three complete, fully unrolled DES pipelines placed in series. A 64-bit block enters with a bundle of three 64-bit keys and an operation select. For an encrypt operation the stages run encrypt, decrypt, encrypt with the first, second and third key. For a decrypt operation they run decrypt, encrypt, decrypt with the keys in reverse order. The engine steers each stage's key and direction itself, so the surrounding logic only supplies the bundle and the operation.

Every DES stage splits each of its sixteen rounds into three register stages: key mixing, substitution, and permute-and-fold. This gives 48 cycles per stage and 144 cycles for the whole engine. The key bundle and the operation bit travel through the pipeline beside their block. A new block can therefore be accepted on every clock, and encrypt and decrypt requests can be mixed freely from one cycle to the next. The block has no state machine: its only control is a valid flag that moves through the pipeline. Nothing is configured for the keying options. Equal keys reduce the engine to single DES because the inner pair of stages cancels out.

Top module: `tdes_ede_top`

## Requirements
- R1: With `in_decrypt`=0 the result is E(key_c, D(key_b, E(key_a, block))). Consequences: with key_a = key_b the result equals single DES under key_c, and with key_b = key_c it equals single DES under key_a.
- R2: With `in_decrypt`=1 the result is D(key_a, E(key_b, D(key_c, block))). Consequences: with key_a = key_b it equals single-DES decryption under key_c, and with key_b = key_c it equals single-DES decryption under key_a.
- R3: With all three keys equal the engine matches single DES. Bit 63 of every block and key port is DES bit 1. Under the all-zero key, 8000000000000000 encrypts to 95F8A5E5DD31D900. Under key 133457799BBCDFF1, 0123456789ABCDEF encrypts to 85E813540F0AB405.
- R4: Encrypting a block and then decrypting the result with the same bundle returns the original block. This holds for independent keys, for key_c = key_a, and for all keys equal, with no setting changed.
- R5: `out_valid` and `out_block` for a block accepted on a rising edge (with `in_valid`=1) appear exactly 144 rising edges later. The first DES stage alone takes 48 edges.
- R6: A block can be accepted on every clock, with encrypt and decrypt operations interleaved in any pattern. Results leave in the order the blocks entered.
- R7: While `rst_n` is low `out_valid` is 0. Blocks still in flight when reset is asserted never produce a valid result.
- R8: A cycle with `in_valid`=0 produces no result: 144 edges later `out_valid` is 0, whatever the data, key and operation inputs held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Accept the block on this edge |
| in_decrypt | input | 1 | 0 = Triple-DES encrypt, 1 = Triple-DES decrypt |
| in_block | input | 64 | Input block, bit 63 = DES bit 1 |
| key_a | input | 64 | First key of the bundle |
| key_b | input | 64 | Second (middle) key of the bundle |
| key_c | input | 64 | Third key of the bundle |
| out_valid | output | 1 | Result valid |
| out_block | output | 64 | Result block |

## Verification
Each accepted block owes its result exactly 144 rising edges after acceptance. The bench drives inputs just after a falling edge and samples outputs on the falling edge 144 cycles later. It records the cycle number of every issued block and of every valid result, and pairs them in order, so a result that arrives one cycle early or late fails the same way as a wrong value. The inner boundary is 48 edges, at the first stage's output. Reset and idle cycles are judged by the count of results after a full 160-cycle drain.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

    localparam int BLK_W     = 64;
    localparam int HALF_W    = BLK_W / 2;
    localparam int KEY_W     = 64;
    localparam int CD_W      = 56;
    localparam int CD_HALF   = CD_W / 2;
    localparam int SUBKEY_W  = 48;
    localparam int ROUNDS    = 16;
    localparam int RND_REGS  = 3;
    localparam int STAGE_LAT = ROUNDS * RND_REGS;
    localparam int N_STAGE   = 3;
    localparam int TDES_LAT  = STAGE_LAT * N_STAGE;

    localparam logic [8*32-1:0] P_TAB = {
        8'd16, 8'd7,  8'd20, 8'd21, 8'd29, 8'd12, 8'd28, 8'd17,
        8'd1,  8'd15, 8'd23, 8'd26, 8'd5,  8'd18, 8'd31, 8'd10,
        8'd2,  8'd8,  8'd24, 8'd14, 8'd32, 8'd27, 8'd3,  8'd9,
        8'd19, 8'd13, 8'd30, 8'd6,  8'd22, 8'd11, 8'd4,  8'd25};

    localparam logic [8*56-1:0] PC1_TAB = {
        8'd57, 8'd49, 8'd41, 8'd33, 8'd25, 8'd17, 8'd9,
        8'd1,  8'd58, 8'd50, 8'd42, 8'd34, 8'd26, 8'd18,
        8'd10, 8'd2,  8'd59, 8'd51, 8'd43, 8'd35, 8'd27,
        8'd19, 8'd11, 8'd3,  8'd60, 8'd52, 8'd44, 8'd36,
        8'd63, 8'd55, 8'd47, 8'd39, 8'd31, 8'd23, 8'd15,
        8'd7,  8'd62, 8'd54, 8'd46, 8'd38, 8'd30, 8'd22,
        8'd14, 8'd6,  8'd61, 8'd53, 8'd45, 8'd37, 8'd29,
        8'd21, 8'd13, 8'd5,  8'd28, 8'd20, 8'd12, 8'd4};

    localparam logic [8*48-1:0] PC2_TAB = {
        8'd14, 8'd17, 8'd11, 8'd24, 8'd1,  8'd5,
        8'd3,  8'd28, 8'd15, 8'd6,  8'd21, 8'd10,
        8'd23, 8'd19, 8'd12, 8'd4,  8'd26, 8'd8,
        8'd16, 8'd7,  8'd27, 8'd20, 8'd13, 8'd2,
        8'd41, 8'd52, 8'd31, 8'd37, 8'd47, 8'd55,
        8'd30, 8'd40, 8'd51, 8'd45, 8'd33, 8'd48,
        8'd44, 8'd49, 8'd39, 8'd56, 8'd34, 8'd53,
        8'd46, 8'd42, 8'd50, 8'd36, 8'd29, 8'd32};

    // Substitution tables, 64 nibbles each, entry 0 in the top nibble.
    localparam logic [255:0] SBOX_TAB [0:7] = '{
        256'hE4D12FB83A6C59070F74E2D1A6CB953841E8D62BFC973A50FC8249175B3EA06D,
        256'hF18E6B34972DC05A3D47F28EC01A69B50E7BA4D158C6932FD8A13F42B67C05E9,
        256'hA09E63F51DC7B428D709346A285ECBF1D6498F30B12C5AE71AD069874FE3B52C,
        256'h7DE3069A1285BC4FD8B56F03472C1AE9A690CB7DF13E52843F06A1D8945BC72E,
        256'h2C417AB6853FD0E9EB2C47D150FA3986421BAD78F9C5630EB8C71E2D6F09A453,
        256'hC1AF92680D34E75BAF427C9561DE0B389EF528C3704A1DB6432C95FABE17608D,
        256'h4B2EF08D3C975A61D0B7491AE35C2F8614BDC37EAF6805926BD814A7950FE23C,
        256'hD2846FB1A93E50C71FD8A374C56B0E927B419CE206ADF35821E74A8DFC90356B};

    // DES bit numbers are 1-based from the MSB.
    function automatic int ip_src(input int i);
        int row;
        int col;
        row = i / 8;
        col = i % 8;
        return ((row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4))) - 8 * col;
    endfunction

    function automatic logic [63:0] init_perm(input logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[63 - i] = x[6'(64 - ip_src(i))];
        return y;
    endfunction

    function automatic logic [63:0] final_perm(input logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[6'(64 - ip_src(i))] = x[63 - i];
        return y;
    endfunction

    function automatic logic [47:0] expand(input logic [31:0] x);
        logic [47:0] y;
        for (int g = 0; g < 8; g++)
            for (int j = 0; j < 6; j++)
                y[47 - (6 * g + j)] = x[5'(31 - ((4 * g + j + 31) % 32))];
        return y;
    endfunction

    function automatic logic [31:0] pbox(input logic [31:0] x);
        logic [31:0] y;
        for (int i = 0; i < 32; i++) y[31 - i] = x[5'(32 - int'(P_TAB[8 * (31 - i) +: 8]))];
        return y;
    endfunction

    function automatic logic [55:0] pc1(input logic [63:0] x);
        logic [55:0] y;
        for (int i = 0; i < 56; i++) y[55 - i] = x[6'(64 - int'(PC1_TAB[8 * (55 - i) +: 8]))];
        return y;
    endfunction

    function automatic logic [47:0] pc2(input logic [55:0] x);
        logic [47:0] y;
        for (int i = 0; i < 48; i++) y[47 - i] = x[6'(56 - int'(PC2_TAB[8 * (47 - i) +: 8]))];
        return y;
    endfunction

    function automatic logic [31:0] subst(input logic [47:0] x);
        logic [31:0] y;
        logic [5:0]  a;
        int          idx;
        for (int b = 0; b < 8; b++) begin
            a   = x[47 - 6 * b -: 6];
            idx = int'({a[5], a[0]}) * 16 + int'(a[4:1]);
            y[31 - 4 * b -: 4] = SBOX_TAB[b][4 * (63 - idx) +: 4];
        end
        return y;
    endfunction

    function automatic logic [27:0] rot28(input logic [27:0] v, input logic right, input int n);
        if (right) return (v >> n) | (v << (28 - n));
        else       return (v << n) | (v >> (28 - n));
    endfunction

    function automatic int enc_shift(input int rnd);
        return (rnd == 1 || rnd == 2 || rnd == 9 || rnd == 16) ? 1 : 2;
    endfunction

    function automatic int dec_shift(input int rnd);
        return (rnd == 1) ? 0 : enc_shift(18 - rnd);
    endfunction

endpackage

// File: rtl/des_round.sv
module des_round
    import tdes_pkg::*;
#(
    parameter int RND  = 1,
    parameter int SB_W = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic                in_dec,
    input  logic [HALF_W-1:0]   in_l,
    input  logic [HALF_W-1:0]   in_r,
    input  logic [CD_W-1:0]     in_cd,
    input  logic [SB_W-1:0]     in_sb,
    output logic                out_vld,
    output logic                out_dec,
    output logic [HALF_W-1:0]   out_l,
    output logic [HALF_W-1:0]   out_r,
    output logic [CD_W-1:0]     out_cd,
    output logic [SB_W-1:0]     out_sb
);
    localparam int SH_ENC = enc_shift(RND);
    localparam int SH_DEC = dec_shift(RND);

    logic [CD_W-1:0]     cd_sh;
    logic [SUBKEY_W-1:0] mix;
    logic [HALF_W-1:0]   sub;

    // stage A: key rotate and mix
    logic                a_vld, a_dec;
    logic [HALF_W-1:0]   a_l, a_r;
    logic [CD_W-1:0]     a_cd;
    logic [SUBKEY_W-1:0] a_mix;
    logic [SB_W-1:0]     a_sb;
    // stage B: substitution
    logic                b_vld, b_dec;
    logic [HALF_W-1:0]   b_l, b_r, b_sub;
    logic [CD_W-1:0]     b_cd;
    logic [SB_W-1:0]     b_sb;

    always_comb begin
        cd_sh = {rot28(in_cd[CD_W-1:CD_HALF], in_dec, in_dec ? SH_DEC : SH_ENC),
                 rot28(in_cd[CD_HALF-1:0],    in_dec, in_dec ? SH_DEC : SH_ENC)};
        mix   = expand(in_r) ^ pc2(cd_sh);
        sub   = subst(a_mix);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_vld   <= 1'b0;
            b_vld   <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            a_vld   <= in_vld;
            b_vld   <= a_vld;
            out_vld <= b_vld;
        end
    end

    always_ff @(posedge clk) begin
        a_dec   <= in_dec;
        a_l     <= in_l;
        a_r     <= in_r;
        a_cd    <= cd_sh;
        a_mix   <= mix;
        a_sb    <= in_sb;
        b_dec   <= a_dec;
        b_l     <= a_l;
        b_r     <= a_r;
        b_cd    <= a_cd;
        b_sub   <= sub;
        b_sb    <= a_sb;
        out_dec <= b_dec;
        out_l   <= b_r;
        out_r   <= b_l ^ pbox(b_sub);
        out_cd  <= b_cd;
        out_sb  <= b_sb;
    end
endmodule

// File: rtl/des_core.sv
module des_core
    import tdes_pkg::*;
#(
    parameter int SB_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_dec,
    input  logic [BLK_W-1:0]  in_blk,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [SB_W-1:0]   in_sb,
    output logic              out_vld,
    output logic              out_dec,
    output logic [BLK_W-1:0]  out_blk,
    output logic [SB_W-1:0]   out_sb
);
    logic              vld [0:ROUNDS];
    logic              dec [0:ROUNDS];
    logic [HALF_W-1:0] l   [0:ROUNDS];
    logic [HALF_W-1:0] r   [0:ROUNDS];
    logic [CD_W-1:0]   cd  [0:ROUNDS];
    logic [SB_W-1:0]   sb  [0:ROUNDS];
    logic [BLK_W-1:0]  perm_in;
    logic [CD_W-1:0]   cd_tail_unused;

    assign perm_in        = init_perm(in_blk);
    assign vld[0]         = in_vld;
    assign dec[0]         = in_dec;
    assign l[0]           = perm_in[BLK_W-1:HALF_W];
    assign r[0]           = perm_in[HALF_W-1:0];
    assign cd[0]          = pc1(in_key);
    assign sb[0]          = in_sb;
    assign cd_tail_unused = cd[ROUNDS];

    for (genvar g = 0; g < ROUNDS; g++) begin : g_rnd
        des_round #(.RND(g + 1), .SB_W(SB_W)) u_rnd (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (vld[g]),
            .in_dec  (dec[g]),
            .in_l    (l[g]),
            .in_r    (r[g]),
            .in_cd   (cd[g]),
            .in_sb   (sb[g]),
            .out_vld (vld[g + 1]),
            .out_dec (dec[g + 1]),
            .out_l   (l[g + 1]),
            .out_r   (r[g + 1]),
            .out_cd  (cd[g + 1]),
            .out_sb  (sb[g + 1])
        );
    end

    assign out_vld = vld[ROUNDS];
    assign out_dec = dec[ROUNDS];
    assign out_blk = final_perm({r[ROUNDS], l[ROUNDS]});
    assign out_sb  = sb[ROUNDS];
endmodule

// File: rtl/tdes_ede_top.sv
module tdes_ede_top
    import tdes_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_decrypt,
    input  logic [BLK_W-1:0]  in_block,
    input  logic [KEY_W-1:0]  key_a,
    input  logic [KEY_W-1:0]  key_b,
    input  logic [KEY_W-1:0]  key_c,
    output logic              out_valid,
    output logic [BLK_W-1:0]  out_block
);
    localparam int SB1_W = 2 * KEY_W;
    localparam int SB2_W = KEY_W;

    logic [KEY_W-1:0] s1_key;
    logic [SB1_W-1:0] s1_sb_in, s1_sb;
    logic             s1_vld, s1_dec;
    logic [BLK_W-1:0] s1_blk;
    logic [SB2_W-1:0] s2_sb;
    logic             s2_vld, s2_dec;
    logic [BLK_W-1:0] s2_blk;
    logic             s3_dec_unused;
    logic             s3_sb_unused;

    // Decrypt reverses the key order; later keys ride beside the block.
    assign s1_key   = in_decrypt ? key_c : key_a;
    assign s1_sb_in = {key_b, in_decrypt ? key_a : key_c};

    des_core #(.SB_W(SB1_W)) u_stage1 (
        .clk (clk), .rst_n (rst_n),
        .in_vld (in_valid), .in_dec (in_decrypt), .in_blk (in_block),
        .in_key (s1_key), .in_sb (s1_sb_in),
        .out_vld (s1_vld), .out_dec (s1_dec), .out_blk (s1_blk), .out_sb (s1_sb)
    );

    des_core #(.SB_W(SB2_W)) u_stage2 (
        .clk (clk), .rst_n (rst_n),
        .in_vld (s1_vld), .in_dec (~s1_dec), .in_blk (s1_blk),
        .in_key (s1_sb[SB1_W-1:KEY_W]), .in_sb (s1_sb[KEY_W-1:0]),
        .out_vld (s2_vld), .out_dec (s2_dec), .out_blk (s2_blk), .out_sb (s2_sb)
    );

    des_core #(.SB_W(1)) u_stage3 (
        .clk (clk), .rst_n (rst_n),
        .in_vld (s2_vld), .in_dec (~s2_dec), .in_blk (s2_blk),
        .in_key (s2_sb), .in_sb (1'b0),
        .out_vld (out_valid), .out_dec (s3_dec_unused), .out_blk (out_block),
        .out_sb (s3_sb_unused)
    );
endmodule

// File: rtl/tdes_ede_chk.sv
module tdes_ede_chk
    import tdes_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mid_valid,
    input logic             out_valid,
    input logic [BLK_W-1:0] out_block
);
    logic [TDES_LAT-1:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[TDES_LAT-2:0], in_valid};
    end

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hist[TDES_LAT-1] |-> out_valid);

    assert_stage1_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mid_valid == hist[STAGE_LAT-1]);

    assert_no_phantom_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hist[TDES_LAT-1] |-> !out_valid);

    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |-> !out_valid);

    assert_result_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_block));
endmodule

bind tdes_ede_top tdes_ede_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mid_valid (s1_vld),
    .out_valid (out_valid),
    .out_block (out_block)
);

// File: tb/tdes_ede_top_tb_top.sv
module tdes_ede_top_tb_top;
    localparam int LAT   = 144;
    localparam int MAXQ  = 512;
    localparam int NRAND = 40;

    logic        clk = 1'b0;
    logic        rst_n, in_valid, in_decrypt;
    logic [63:0] in_block, key_a, key_b, key_c, out_block;
    logic        out_valid;

    always #10 clk = ~clk;

    tdes_ede_top dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_decrypt (in_decrypt),
        .in_block (in_block), .key_a (key_a), .key_b (key_b), .key_c (key_c),
        .out_valid (out_valid), .out_block (out_block)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    int n_iss = 0, n_cap = 0;
    logic [63:0] exp_blk [0:MAXQ-1];
    bit          exp_on  [0:MAXQ-1];
    string       exp_tag [0:MAXQ-1];
    int          iss_cyc [0:MAXQ-1];
    logic [63:0] cap_blk [0:MAXQ-1];
    int          cap_cyc [0:MAXQ-1];
    logic [63:0] rk1 [0:NRAND-1];
    logic [63:0] rk2 [0:NRAND-1];
    logic [63:0] rk3 [0:NRAND-1];
    logic [63:0] rpt [0:NRAND-1];

    localparam logic [63:0] KZ  = 64'h0;
    localparam logic [63:0] KB  = 64'h133457799BBCDFF1;
    localparam logic [63:0] KA  = 64'h0E329232EA6D0D73;
    localparam logic [63:0] PT0 = 64'h8000000000000000;
    localparam logic [63:0] CT0 = 64'h95F8A5E5DD31D900;
    localparam logic [63:0] PT1 = 64'h0123456789ABCDEF;
    localparam logic [63:0] CT1 = 64'h85E813540F0AB405;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (out_valid && n_cap < MAXQ) begin
            cap_blk[n_cap] = out_block;
            cap_cyc[n_cap] = cyc;
            n_cap++;
        end
    endtask

    task automatic issue(input bit dec, input logic [63:0] blk, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] c, input bit has_exp,
                         input logic [63:0] expv, input string tag);
        tick();
        in_valid   = 1'b1;
        in_decrypt = dec;
        in_block   = blk;
        key_a      = a;
        key_b      = b;
        key_c      = c;
        exp_blk[n_iss] = expv;
        exp_on[n_iss]  = has_exp;
        exp_tag[n_iss] = tag;
        iss_cyc[n_iss] = cyc;
        n_iss++;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            tick();
            in_valid   = 1'b0;
            in_decrypt = 1'($urandom);
            in_block   = {$urandom, $urandom};
            key_a      = {$urandom, $urandom};
            key_b      = {$urandom, $urandom};
            key_c      = {$urandom, $urandom};
        end
    endtask

    task automatic verify(input int from);
        check(n_cap == n_iss, "R6/R8 result count", 64'(n_cap), 64'(n_iss));
        for (int k = from; k < n_iss && k < n_cap; k++) begin
            check(cap_cyc[k] == iss_cyc[k] + LAT, "R5 latency", 64'(cap_cyc[k] - iss_cyc[k]), 64'(LAT));
            if (exp_on[k]) check(cap_blk[k] === exp_blk[k], exp_tag[k], cap_blk[k], exp_blk[k]);
        end
    endtask

    initial begin
        int base;
        int opt;
        void'($urandom(32'h1F2E3D4C));
        rst_n = 1'b0; in_valid = 1'b0; in_decrypt = 1'b0;
        in_block = '0; key_a = '0; key_b = '0; key_c = '0;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7 reset", 64'(out_valid), 64'd0);
        end
        rst_n = 1'b1;
        idle(2);

        // Directed vectors, back to back with mixed directions.
        base = n_iss;
        issue(0, PT0, KZ, KZ, KZ, 1, CT0, "R3 zero key encrypt");
        issue(0, PT1, KB, KB, KB, 1, CT1, "R3 equal keys encrypt");
        issue(1, CT0, KZ, KZ, KZ, 1, PT0, "R2 zero key decrypt");
        issue(0, PT1, KA, KA, KB, 1, CT1, "R1 third key last");
        issue(0, PT1, KB, KA, KA, 1, CT1, "R1 first key first");
        issue(1, CT1, KA, KA, KB, 1, PT1, "R2 third key first");
        issue(1, CT1, KB, KA, KA, 1, PT1, "R2 first key last");
        idle(20);
        issue(1, CT1, KB, KB, KB, 1, PT1, "R3 equal keys decrypt");
        idle(160);
        verify(base);

        // Random encrypts over the three keying options.
        base = n_iss;
        for (int i = 0; i < NRAND; i++) begin
            rk1[i] = {$urandom, $urandom};
            rk2[i] = {$urandom, $urandom};
            rk3[i] = {$urandom, $urandom};
            opt = int'($urandom % 3);
            if (opt >= 1) rk3[i] = rk1[i];
            if (opt == 2) rk2[i] = rk1[i];
            rpt[i] = {$urandom, $urandom};
            issue(0, rpt[i], rk1[i], rk2[i], rk3[i], 0, '0, "R4 encrypt");
            if ($urandom % 4 == 0) idle(1);
        end
        idle(160);
        verify(base);

        // Decrypt them back, interleaved with known encrypts.
        begin
            int cbase;
            cbase = base;
            base = n_iss;
            for (int i = 0; i < NRAND; i++) begin
                issue(1, cap_blk[cbase + i], rk1[i], rk2[i], rk3[i], 1, rpt[i], "R4 round trip");
                if (i % 2 == 0) issue(0, PT0, KZ, KZ, KZ, 1, CT0, "R6 interleaved encrypt");
            end
        end
        idle(160);
        verify(base);

        // Reset while blocks are in flight.
        base = n_cap;
        issue(0, PT0, KZ, KZ, KZ, 0, '0, "R7");
        issue(1, CT0, KZ, KZ, KZ, 0, '0, "R7");
        idle(30);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(160);
        check(n_cap == base, "R7 flushed blocks", 64'(n_cap), 64'(base));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule